// File: doc/BRIEF.md
# Linked-Record Memory Copy Channel

This block is one DMA channel that runs through a chain of transfer records kept in memory. Each record names a source address, a destination address, a byte count and the address of the record that follows it. The channel reads a record, copies its data one 32-bit word at a time over a single request/response memory port, and then moves to the following record. It stops when a record's count is used up and that record's link is zero.

Software controls the channel through four small registers. It sets the link register and issues a start command. It can choose to be interrupted after every record or only when the whole chain ends. It reads a running flag to see whether the channel is busy. A flag bit, a writable link register and the start command let software add records to a chain while the channel is working on it. If the channel has already seen a zero link, software reloads the link register and starts the channel again once the chain-end interrupt arrives.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the channel is idle, the running flag and the interrupt are 0, the link register reads 0 and no memory request is raised.
- R2: A record is four consecutive 32-bit words at byte offsets +0, +4, +8 and +12 from the record address: source, destination, byte count, link. The channel reads them in that order.
- R3: For each data word the channel reads from the source and then writes that word to the destination. Both addresses advance by 4 per word, and the remaining count (register 2) drops by 4 and stops at 0. Transfers happen in exactly the order the records define.
- R4: When a record's count reaches zero and its link is non-zero, the channel fetches the linked record without any software action and stays running.
- R5: When a record's count reaches zero and its link is zero, the running flag (bit 2 of register 0) falls to 0.
- R6: Bit 0 of register 0 selects the interrupt mode. With 0, the interrupt is set at the end of every record. With 1, it is set only when the chain ends.
- R7: The interrupt is bit 3 of register 0 and drives the `irq` output. It stays set until software writes register 0 with bit 3 = 1. Writing bit 3 = 0 leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R8: A record whose byte count is 0 moves no data. The channel goes straight on to its link.
- R9: Writing register 0 with bit 1 = 1 starts an idle channel at the record addressed by the link register. The command is ignored when the channel is running or when the link is 0.
- R10: Software can read and write the link register (register 1). After each record is loaded, it holds that record's link word. A link word that software changes in memory before the channel reads it is followed.
- R11: A memory request stays raised with unchanged address, write flag and write data until it is accepted. After a read is accepted, no new request is raised until its response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control/status, 1 link, 2 remaining count |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Sticky interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | AW | Byte address of request |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |

## Verification
The first chain has three records, and its middle record has a zero count. It is run in per-record interrupt mode with the memory always ready, which separates interrupts taken at each record from an interrupt taken once at chain end, and shows that a zero-count record moves no data. The second chain runs in end-only mode with the ready signal stalling every third cycle, so a request that does not stay held or a lost response would show up as a transfer-order mismatch. Later runs change a record's link in memory before the channel reads it, issue a start command while the channel is busy, and reload the link register after the chain has ended. Together these show the difference between following a live append, ignoring a start, and restarting correctly.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  typedef enum logic [2:0] {IDLE, FETCH_DESC, READ_DATA, WRITE_DATA, CHECK_END} st_t;

  st_t           st;
  logic [1:0]    idx;
  logic          pend;
  logic          end_only;
  logic [AW-1:0] base, src, dst, cnt, nxt;
  logic [DW-1:0] hold;

  wire ctrl_wr   = reg_wr && reg_addr == 2'd0;
  wire ptr_wr    = reg_wr && reg_addr == 2'd1;
  wire active    = st != IDLE;
  wire start     = ctrl_wr && reg_wdata[1] && !active && nxt != '0;
  wire hs        = mem_req_valid && mem_req_ready;
  wire rsp       = pend && mem_rsp_valid;
  wire last_word = cnt <= STEP;
  wire set_irq   = st == CHECK_END && (!end_only || nxt == '0);

  assign mem_req_valid = (st == FETCH_DESC || st == READ_DATA) ? !pend : (st == WRITE_DATA);
  assign mem_req_we    = st == WRITE_DATA;
  assign mem_req_addr  = st == FETCH_DESC ? base + AW'(idx) * STEP :
                         st == WRITE_DATA ? dst : src;
  assign mem_req_wdata = hold;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DW'({irq, active, 1'b0, end_only});
      2'd1:    reg_rdata = DW'(nxt);
      2'd2:    reg_rdata = DW'(cnt);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      idx      <= '0;
      pend     <= 1'b0;
      end_only <= 1'b0;
      irq      <= 1'b0;
      base     <= '0;
      src      <= '0;
      dst      <= '0;
      cnt      <= '0;
      nxt      <= '0;
      hold     <= '0;
    end else begin
      if (ctrl_wr) end_only <= reg_wdata[0];
      if (set_irq) irq <= 1'b1;
      else if (ctrl_wr && reg_wdata[3]) irq <= 1'b0;
      if (ptr_wr) nxt <= reg_wdata[AW-1:0];
      if (hs && !mem_req_we) pend <= 1'b1;
      else if (rsp) pend <= 1'b0;

      case (st)
        IDLE: if (start) begin
          base <= nxt;
          idx  <= '0;
          st   <= FETCH_DESC;
        end
        FETCH_DESC: if (rsp) begin
          case (idx)
            2'd0: src <= mem_rsp_data[AW-1:0];
            2'd1: dst <= mem_rsp_data[AW-1:0];
            2'd2: cnt <= mem_rsp_data[AW-1:0];
            default: nxt <= mem_rsp_data[AW-1:0];
          endcase
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= (cnt == '0) ? CHECK_END : READ_DATA;
        end
        READ_DATA: if (rsp) begin
          hold <= mem_rsp_data;
          st   <= WRITE_DATA;
        end
        WRITE_DATA: if (hs) begin
          src <= src + STEP;
          dst <= dst + STEP;
          cnt <= last_word ? '0 : cnt - STEP;
          st  <= last_word ? CHECK_END : READ_DATA;
        end
        CHECK_END: if (nxt == '0) st <= IDLE;
          else begin
            base <= nxt;
            idx  <= '0;
            st   <= FETCH_DESC;
          end
        default: st <= IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
    $stable(mem_req_we) && $stable(mem_req_wdata)); // R11
  AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(ctrl_wr && reg_wdata[3]) |=> irq); // R7
  AST_NULL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    st == CHECK_END && nxt == '0 |=> !active); // R5
  AST_START_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_req_valid && !mem_req_we && mem_req_addr == $past(nxt)); // R9
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    st == FETCH_DESC && rsp && idx == 2'd3 && cnt == '0 |=> st == CHECK_END); // R8
endmodule

// File: tb/dma_chain_engine_test.sv
`timescale 1ns/1ps
module dma_chain_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, fails = 0, irq_rises = 0, cyc = 0;
  bit done = 0, stall_en = 0, prev_irq = 0;
  logic [31:0] mem [0:255];
  logic [64:0] expq [$];
  logic        prev_stall = 0;
  logic [31:0] prev_addr = '0;

  always #4 clk = ~clk;

  dma_chain_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  assign mem_req_ready = !stall_en || (cyc % 3 != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every accepted request with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !prev_irq) irq_rises++;
      prev_irq = irq;
      if (prev_stall) chk(mem_req_valid && mem_req_addr == prev_addr, "R11 held request", mem_req_addr, prev_addr);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (expq.size() == 0) chk(1'b0, "R2/R3 unexpected request", mem_req_addr, 32'hffffffff);
        else begin
          logic [64:0] e;
          e = expq.pop_front();
          chk(mem_req_we == e[64] && mem_req_addr == e[63:32], "R2/R3 request order",
              mem_req_addr, e[63:32]);
          if (e[64]) chk(mem_req_wdata == e[31:0], "R3 copied data", mem_req_wdata, e[31:0]);
        end
      end
    end
  end

  task automatic push_rec(input int base, input int src, input int dst, input int cnt, input int nxt);
    mem[base/4] = src; mem[base/4+1] = dst; mem[base/4+2] = cnt; mem[base/4+3] = nxt;
    for (int k = 0; k < 4; k++) expq.push_back({1'b0, 32'(base + 4*k), 32'h0});
    for (int i = 0; i < (cnt + 3) / 4; i++) begin
      expq.push_back({1'b0, 32'(src + 4*i), 32'h0});
      expq.push_back({1'b1, 32'(dst + 4*i), mem[src/4 + i]});
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output bit got);
    got = 0;
    for (int n = 0; n < 2000 && !got; n++) begin
      @(negedge clk); #1 got = irq;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h4;
    for (int n = 0; n < 2000 && v[2]; n++) rd(2'd0, v);
    chk(!v[2], "R5 channel went idle", v, 32'h0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    bit got;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i * 32'h1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk(v == 0 && !irq, "R1 control after reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 link after reset", v, 0);
    chk(!mem_req_valid, "R1 no request after reset", mem_req_valid, 0);

    wr(2'd0, 32'h2);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk(!v[2], "R9 start with zero link ignored", v, 0);

    // chain A, per-record interrupts, middle record empty
    push_rec(32'h100, 32'h200, 32'h300, 12, 32'h110);
    push_rec(32'h110, 32'h2f0, 32'h3f0, 0,  32'h120);
    push_rec(32'h120, 32'h210, 32'h320, 8,  32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h100);
    wr(2'd0, 32'h2);
    for (int r = 0; r < 3; r++) begin
      wait_irq(got);
      chk(got, "R6 per-record interrupt", got, 1);
      rd(2'd0, v);
      chk(v[2] == (r < 2), r < 2 ? "R4 continues to next record" : "R5 stops at zero link", v[2], r < 2);
      wr(2'd0, 32'h8);
      chk(!irq, "R7 write one clears interrupt", irq, 0);
    end
    rd(2'd2, v); chk(v == 0, "R3 remaining count zero", v, 0);
    chk(expq.size() == 0, "R8 empty record moved no data", expq.size(), 0);

    // chain B, end-only interrupt, stalling memory
    stall_en = 1;
    push_rec(32'h130, 32'h220, 32'h340, 8, 32'h140);
    push_rec(32'h140, 32'h230, 32'h350, 4, 32'h0);
    wr(2'd0, 32'h1);
    irq_rises = 0;
    wr(2'd1, 32'h130);
    wr(2'd0, 32'h3);
    repeat (5) @(negedge clk);
    wait_idle();
    chk(irq && irq_rises == 1, "R6 single interrupt at chain end", irq_rises, 1);
    wr(2'd0, 32'h1);
    chk(irq, "R7 write zero keeps interrupt", irq, 1);
    wr(2'd0, 32'h9);
    chk(!irq, "R7 clear", irq, 0);
    rd(2'd1, v); chk(v == 0, "R10 link holds last record link", v, 0);
    stall_en = 0;

    // chain C, link appended in memory while running
    push_rec(32'h150, 32'h240, 32'h360, 16, 32'h0);
    push_rec(32'h160, 32'h260, 32'h380, 8,  32'h0);
    irq_rises = 0;
    wr(2'd1, 32'h150);
    wr(2'd0, 32'h3);
    mem[32'h15C/4] = 32'h160;
    v = 0;
    for (int n = 0; n < 200 && v != 32'h160; n++) rd(2'd1, v);
    chk(v == 32'h160, "R10 link loaded from appended record", v, 32'h160);
    wr(2'd0, 32'h3);
    rd(2'd0, v); chk(v[2], "R9 start while running ignored, still running", v, 32'h4);
    wait_idle();
    chk(irq_rises == 1, "R6 two records one end interrupt", irq_rises, 1);
    wr(2'd0, 32'h9);

    // chain E ends, then software reloads link and restarts
    push_rec(32'h170, 32'h270, 32'h390, 4, 32'h0);
    wr(2'd1, 32'h170);
    wr(2'd0, 32'h3);
    wait_irq(got);
    chk(got, "R6 chain end interrupt", got, 1);
    wait_idle();
    push_rec(32'h180, 32'h280, 32'h3a0, 12, 32'h0);
    wr(2'd1, 32'h180);
    rd(2'd1, v); chk(v == 32'h180, "R10 link write readback", v, 32'h180);
    wr(2'd0, 32'h9);
    wr(2'd0, 32'h3);
    repeat (3) @(negedge clk);
    wait_idle();
    chk(irq, "R9 restart completed with interrupt", irq, 1);
    chk(mem[32'h3a8/4] == mem[32'h288/4], "R3 last word in memory", mem[32'h3a8/4], mem[32'h288/4]);
    chk(expq.size() == 0, "R3 all transfers seen", expq.size(), 0);
    summary();
  end
endmodule